// File: doc/BRIEF.md
# Shader Operand Swizzle and Mask Unit

This unit prepares the operands for one shader instruction word. It decodes the two source-register fields into a register bank and an index. The surrounding register files are read with that bank and index, and they return a 4-component vector for each source in the same cycle. The unit reorders the components of each vector by a per-component selector. It also produces a per-component destination write enable. The selectors and the write-enable mask are not taken from the instruction. They come from an operand-descriptor table indexed by a 5-bit field of the instruction. The arithmetic that consumes the operands lies outside this unit.

The descriptor table is filled through a small register interface. A write to the load-start address clears the table's write pointer. A write to any of the eight data addresses stores the word at the pointer, and the pointer then advances. The swizzled operands, the write enable, the destination field and the opcode are registered. They appear one cycle after the instruction is presented.

Top module: `opnd_swz_unit`

## Requirements
- R1: After reset, `out_valid` is 0, `op1`, `op2` and `dst_we` are all zero, every descriptor entry reads as zero, and the table write pointer is 0.
- R2: A write with `cfg_addr` = 0 clears the write pointer. A write with `cfg_addr` in 1..8 stores `cfg_wdata` at the pointer and then advances the pointer by one. All eight data addresses behave identically.
- R3: The table holds 32 entries. Data writes issued after entry 31 has been written are dropped and leave every entry unchanged.
- R4: The src1 field is instruction bits 18:12. It decodes to bank 0 (input) with index v for v = 0x00..0x0F, to bank 1 (temporary) with index v-0x10 for v = 0x10..0x1F, and to bank 2 (uniform) with index v-0x20 for v = 0x20..0x7F. `src1_bank` and `src1_idx` are combinational.
- R5: The src2 field is instruction bits 11:7. It decodes to bank 0 with index v for v < 0x10, and to bank 1 with index v-0x10 otherwise. It never selects the uniform bank.
- R6: Vectors carry component x in bits 23:0, y in 47:24, z in 71:48 and w in 95:72. The descriptor id is instruction bits 4:0. In the selected descriptor, the src1 selector for output component 0/1/2/3 sits in bits 12:11 / 10:9 / 8:7 / 6:5. Selector code 0..3 picks source component x..w. `op1` component i equals the `src1_rdata` component named by selector i.
- R7: The src2 selectors for output component 0/1/2/3 sit in descriptor bits 21:20 / 19:18 / 17:16 / 15:14, and `op2` is formed from `src2_rdata` in the same way as `op1`.
- R8: `dst_we` bit i enables output component i, where x is bit 0. `dst_we` equals descriptor bits 0,1,2,3 taken in that order from bit 3 down to bit 0, so descriptor bit 3 enables x and descriptor bit 0 enables w.
- R9: `out_valid`, `op1`, `op2`, `dst_we`, `dst_sel` (instruction bits 25:19) and `out_opcode` (instruction bits 31:26) reflect the instruction presented with `instr_valid` one cycle earlier. While `instr_valid` is low, `out_valid` drops and the other outputs hold.
- R10: An instruction whose descriptor entry is written in the same cycle sees the entry's previous content.
- R11: Writes to `cfg_addr` values 9..15 have no effect on the table or on the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | 0 = load start, 1..8 = table data, others ignored |
| cfg_wdata | input | 32 | Configuration write data |
| instr_valid | input | 1 | Instruction word is present |
| instr | input | 32 | Shader instruction word |
| src1_bank | output | 2 | src1 bank: 0 input, 1 temporary, 2 uniform |
| src1_idx | output | 7 | src1 index within its bank |
| src2_bank | output | 2 | src2 bank: 0 input, 1 temporary |
| src2_idx | output | 4 | src2 index within its bank |
| src1_rdata | input | 96 | src1 vector read from the selected file |
| src2_rdata | input | 96 | src2 vector read from the selected file |
| out_valid | output | 1 | Registered operands are valid |
| op1 | output | 96 | Swizzled first operand |
| op2 | output | 96 | Swizzled second operand |
| dst_we | output | 4 | Per-component destination write enable |
| dst_sel | output | 7 | Registered destination field |
| out_opcode | output | 6 | Registered opcode |

## Verification
A table write and an instruction's descriptor lookup can fall in the same cycle and touch the same entry. The bench provokes this by clearing the pointer and then, on a single clock edge, writing entry 0 with a new mask while presenting an instruction that reads entry 0. The registered `dst_we` must show the old mask. An instruction issued on the next cycle must show the new mask. A second case lands a data write on a full table together with an instruction that reads entry 31, and the result must show that entry 31 is unchanged.

// File: rtl/opsw_pkg.sv
package opsw_pkg;
  localparam int INSTR_W    = 32;
  localparam int DESC_W     = 32;
  localparam int ID_LSB     = 0;
  localparam int ID_W       = 5;
  localparam int SRC2_LSB   = 7;
  localparam int SRC2_W     = 5;
  localparam int SRC1_LSB   = 12;
  localparam int SRC1_W     = 7;
  localparam int DEST_LSB   = 19;
  localparam int DEST_W     = 7;
  localparam int OPC_LSB    = 26;
  localparam int OPC_W      = 6;
  localparam int NCOMP      = 4;
  localparam int SEL_W      = 2;
  localparam int MASK_LSB   = 0;
  localparam int S1_SEL_LSB = 5;   // selector of the last component
  localparam int S2_SEL_LSB = 14;
  localparam int FILE_DEPTH = 16;
  localparam int IDX2_W     = $clog2(FILE_DEPTH);
  localparam int UNI_BASE   = 2 * FILE_DEPTH;
  localparam int NUM_UNI    = (1 << SRC1_W) - UNI_BASE;

  typedef enum logic [1:0] {
    BANK_IN  = 2'd0,
    BANK_TMP = 2'd1,
    BANK_UNI = 2'd2
  } bank_e;
endpackage

// File: rtl/opsw_desc_table.sv
module opsw_desc_table
  import opsw_pkg::*;
#(
  parameter int DEPTH  = 1 << ID_W,
  parameter int DW     = DESC_W,
  parameter int CFG_AW = 4,
  parameter int NALIAS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [DW-1:0]             cfg_wdata,
  input  logic [$clog2(DEPTH)-1:0]  rd_id,
  output logic [DW-1:0]             rd_word
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [PW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] mem_q [DEPTH];
  logic          start_hit, data_hit, store_en;

  always_comb begin
    start_hit = cfg_we && (cfg_addr == '0);
    data_hit  = cfg_we && (cfg_addr >= CFG_AW'(1)) && (cfg_addr <= CFG_AW'(NALIAS));
    store_en  = data_hit && (ptr_q < PW'(DEPTH));
    ptr_d     = ptr_q;
    if (start_hit)     ptr_d = '0;
    else if (store_en) ptr_d = ptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else if (store_en) begin
      mem_q[ptr_q[IW-1:0]] <= cfg_wdata;
    end
  end

  assign rd_word = mem_q[rd_id];

  a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PW'(DEPTH));
  a_r2_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> (ptr_q == '0));
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && ptr_q < PW'(DEPTH)) |=> (ptr_q == $past(ptr_q) + PW'(1)));
  a_r3_ptr_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && ptr_q == PW'(DEPTH)) |=> (ptr_q == PW'(DEPTH)));
  a_r11_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_hit && !data_hit) |=> $stable(ptr_q));
endmodule

// File: rtl/opsw_src_decode.sv
module opsw_src_decode
  import opsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC1_W-1:0] src1_fld,
  input  logic [SRC2_W-1:0] src2_fld,
  output bank_e             src1_bank,
  output logic [SRC1_W-1:0] src1_idx,
  output bank_e             src2_bank,
  output logic [IDX2_W-1:0] src2_idx
);
  always_comb begin
    if (src1_fld < SRC1_W'(FILE_DEPTH)) begin
      src1_bank = BANK_IN;
      src1_idx  = src1_fld;
    end else if (src1_fld < SRC1_W'(UNI_BASE)) begin
      src1_bank = BANK_TMP;
      src1_idx  = src1_fld - SRC1_W'(FILE_DEPTH);
    end else begin
      src1_bank = BANK_UNI;
      src1_idx  = src1_fld - SRC1_W'(UNI_BASE);
    end
  end

  always_comb begin
    src2_bank = src2_fld[SRC2_W-1] ? BANK_TMP : BANK_IN;
    src2_idx  = src2_fld[IDX2_W-1:0];
  end

  // R5: the narrow source never reaches the uniform file
  a_r5_no_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    src2_bank != BANK_UNI);
  a_r4_uniform_range: assert property (@(posedge clk) disable iff (!rst_n)
    (src1_bank == BANK_UNI) |-> (src1_idx < SRC1_W'(NUM_UNI)));
  a_r4_file_range: assert property (@(posedge clk) disable iff (!rst_n)
    (src1_bank != BANK_UNI) |-> (src1_idx < SRC1_W'(FILE_DEPTH)));
endmodule

// File: rtl/opsw_swizzle.sv
module opsw_swizzle
  import opsw_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic [NCOMP*CW-1:0]    vec_in,
  input  logic [NCOMP*SEL_W-1:0] sel,
  output logic [NCOMP*CW-1:0]    vec_out
);
  for (genvar i = 0; i < NCOMP; i++) begin : g_comp
    logic [SEL_W-1:0] s;
    assign s = sel[i*SEL_W +: SEL_W];
    always_comb vec_out[i*CW +: CW] = vec_in[s*CW +: CW];
  end
endmodule

// File: rtl/opnd_swz_unit.sv
module opnd_swz_unit
  import opsw_pkg::*;
#(
  parameter int CW     = 24,
  parameter int CFG_AW = 4,
  parameter int NALIAS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [DESC_W-1:0]    cfg_wdata,
  input  logic                 instr_valid,
  input  logic [INSTR_W-1:0]   instr,
  output logic [1:0]           src1_bank,
  output logic [SRC1_W-1:0]    src1_idx,
  output logic [1:0]           src2_bank,
  output logic [IDX2_W-1:0]    src2_idx,
  input  logic [NCOMP*CW-1:0]  src1_rdata,
  input  logic [NCOMP*CW-1:0]  src2_rdata,
  output logic                 out_valid,
  output logic [NCOMP*CW-1:0]  op1,
  output logic [NCOMP*CW-1:0]  op2,
  output logic [NCOMP-1:0]     dst_we,
  output logic [DEST_W-1:0]    dst_sel,
  output logic [OPC_W-1:0]     out_opcode
);
  localparam int VW    = NCOMP * CW;
  localparam int DEPTH = 1 << ID_W;

  logic [DESC_W-1:0]      desc;
  logic [NCOMP*SEL_W-1:0] sel1, sel2;
  logic [NCOMP-1:0]       we_d;
  logic [VW-1:0]          sw1, sw2;
  bank_e                  b1, b2;

  opsw_desc_table #(
    .DEPTH (DEPTH), .DW (DESC_W), .CFG_AW (CFG_AW), .NALIAS (NALIAS)
  ) u_table (
    .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
    .cfg_wdata (cfg_wdata), .rd_id (instr[ID_LSB +: ID_W]), .rd_word (desc)
  );

  opsw_src_decode u_dec (
    .clk (clk), .rst_n (rst_n),
    .src1_fld (instr[SRC1_LSB +: SRC1_W]), .src2_fld (instr[SRC2_LSB +: SRC2_W]),
    .src1_bank (b1), .src1_idx (src1_idx), .src2_bank (b2), .src2_idx (src2_idx)
  );
  assign src1_bank = b1;
  assign src2_bank = b2;

  // Selector and mask fields are stored last-component first
  for (genvar i = 0; i < NCOMP; i++) begin : g_fields
    assign sel1[i*SEL_W +: SEL_W] = desc[S1_SEL_LSB + SEL_W*(NCOMP-1-i) +: SEL_W];
    assign sel2[i*SEL_W +: SEL_W] = desc[S2_SEL_LSB + SEL_W*(NCOMP-1-i) +: SEL_W];
    assign we_d[i]                = desc[MASK_LSB + NCOMP-1-i];
  end

  opsw_swizzle #(.CW (CW)) u_swz1 (.vec_in (src1_rdata), .sel (sel1), .vec_out (sw1));
  opsw_swizzle #(.CW (CW)) u_swz2 (.vec_in (src2_rdata), .sel (sel2), .vec_out (sw2));

  logic [VW-1:0]     op1_q, op2_q, op1_d, op2_d;
  logic [NCOMP-1:0]  we_q, we_n;
  logic [DEST_W-1:0] dst_q, dst_d;
  logic [OPC_W-1:0]  opc_q, opc_d;
  logic              vld_q;

  always_comb begin
    op1_d = op1_q;
    op2_d = op2_q;
    we_n  = we_q;
    dst_d = dst_q;
    opc_d = opc_q;
    if (instr_valid) begin
      op1_d = sw1;
      op2_d = sw2;
      we_n  = we_d;
      dst_d = instr[DEST_LSB +: DEST_W];
      opc_d = instr[OPC_LSB +: OPC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      op1_q <= '0;
      op2_q <= '0;
      we_q  <= '0;
      dst_q <= '0;
      opc_q <= '0;
    end else begin
      vld_q <= instr_valid;
      op1_q <= op1_d;
      op2_q <= op2_d;
      we_q  <= we_n;
      dst_q <= dst_d;
      opc_q <= opc_d;
    end
  end

  assign out_valid  = vld_q;
  assign op1        = op1_q;
  assign op2        = op2_q;
  assign dst_we     = we_q;
  assign dst_sel    = dst_q;
  assign out_opcode = opc_q;

  logic unused_bits;
  assign unused_bits = ^{instr[6:5], desc[31:22], desc[13], desc[4]};

  a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> out_valid);
  a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> !out_valid);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> ($stable(op1) && $stable(op2) && $stable(dst_we) && $stable(dst_sel)));
  a_r9_dest_follow: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> (dst_sel == $past(instr[DEST_LSB +: DEST_W])));
endmodule

// File: tb/opnd_swz_unit_tb.sv
module opnd_swz_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        instr_valid;
  logic [31:0] instr;
  logic [1:0]  src1_bank, src2_bank;
  logic [6:0]  src1_idx;
  logic [3:0]  src2_idx;
  logic [95:0] src1_rdata, src2_rdata, op1, op2;
  logic        out_valid;
  logic [3:0]  dst_we;
  logic [6:0]  dst_sel;
  logic [5:0]  out_opcode;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  opnd_swz_unit u_dut (
    .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
    .cfg_wdata (cfg_wdata), .instr_valid (instr_valid), .instr (instr),
    .src1_bank (src1_bank), .src1_idx (src1_idx), .src2_bank (src2_bank),
    .src2_idx (src2_idx), .src1_rdata (src1_rdata), .src2_rdata (src2_rdata),
    .out_valid (out_valid), .op1 (op1), .op2 (op2), .dst_we (dst_we),
    .dst_sel (dst_sel), .out_opcode (out_opcode)
  );

  localparam logic [95:0] PAT1 = {24'h44DD04, 24'h33CC03, 24'h22BB02, 24'h11AA01};
  localparam logic [95:0] PAT2 = {24'h8F0008, 24'h7E0007, 24'h6D0006, 24'h5C0005};

  // {expected dst_we, descriptor}
  localparam logic [35:0] VEC [8] = '{
    {4'b0000, 32'h00000000}, {4'b1111, 32'h0000000F},
    {4'b0001, 32'h00000008}, {4'b1000, 32'h00000001},
    {4'b0110, 32'h003FFFE6}, {4'b0011, 32'h0012345C},
    {4'b1100, 32'h80ABCDE3}, {4'b0101, 32'h0031B0DA}
  };

  function automatic logic [95:0] swz(input logic [95:0] v, input logic [31:0] d, input int c0_lsb);
    logic [95:0] r;
    for (int i = 0; i < 4; i++) begin
      int s;
      s = int'(d[c0_lsb - 2*i +: 2]);
      r[24*i +: 24] = v[24*s +: 24];
    end
    return r;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [6:0] dst,
                                     input logic [6:0] s1, input logic [4:0] s2,
                                     input logic [4:0] id);
    return {opc, dst, s1, s2, 2'b00, id};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // present one instruction, return after the registered outputs settle
  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    instr_valid = 1'b1; instr = w;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic dec_chk(input logic [6:0] s1, input logic [4:0] s2,
                         input logic [1:0] eb1, input logic [6:0] ei1,
                         input logic [1:0] eb2, input logic [3:0] ei2);
    instr = mk(6'h0, 7'h0, s1, s2, 5'h0);
    #1;
    chk(src1_bank == eb1 && src1_idx == ei1, "R4 src1 decode",
        {87'h0, src1_bank, src1_idx}, {87'h0, eb1, ei1});
    chk(src2_bank == eb2 && src2_idx == ei2, "R5 src2 decode",
        {90'h0, src2_bank, src2_idx}, {90'h0, eb2, ei2});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    instr_valid = 1'b0; instr = '0; src1_rdata = PAT1; src2_rdata = PAT2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", {95'h0, out_valid}, 96'h0);
    chk(op1 == '0 && op2 == '0, "R1 operands", op1 | op2, 96'h0);
    chk(dst_we == '0, "R1 dst_we", {92'h0, dst_we}, 96'h0);
    issue(mk(6'h0, 7'h0, 7'h0, 5'h0, 5'd31));
    chk(dst_we == 4'b0000 && op1 == {4{PAT1[23:0]}}, "R1 entry clear",
        op1, {4{PAT1[23:0]}});
    // pointer at zero after reset: first data write lands in entry 0
    cfg_wr(4'd1, 32'h00000008);
    issue(mk(6'h0, 7'h0, 7'h0, 5'h0, 5'd0));
    chk(dst_we == 4'b0001, "R1 pointer reset", {92'h0, dst_we}, 96'h1);

    // Vector table: load through rotating aliases, then walk it
    cfg_wr(4'd0, 32'h0);
    for (int i = 0; i < 8; i++) cfg_wr(4'(1 + i), VEC[i][31:0]);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      src1_rdata = (i % 2 == 0) ? PAT1 : PAT2;
      src2_rdata = (i % 2 == 0) ? PAT2 : PAT1;
      w = mk(6'(i + 3), 7'(i * 9), 7'(i * 5), 5'(i * 3), 5'(i));
      issue(w);
      chk(dst_we == VEC[i][35:32], "R8 R2 mask via alias", {92'h0, dst_we}, {92'h0, VEC[i][35:32]});
      chk(op1 == swz(src1_rdata, VEC[i][31:0], 11), "R6 src1 swizzle",
          op1, swz(src1_rdata, VEC[i][31:0], 11));
      chk(op2 == swz(src2_rdata, VEC[i][31:0], 20), "R7 src2 swizzle",
          op2, swz(src2_rdata, VEC[i][31:0], 20));
      chk(out_valid && dst_sel == 7'(i * 9) && out_opcode == 6'(i + 3), "R9 passthrough",
          {88'h0, out_valid, dst_sel}, {88'h0, 1'b1, 7'(i * 9)});
    end

    // R9: outputs hold and valid drops while idle
    src1_rdata = ~PAT1;
    repeat (2) @(negedge clk);
    chk(!out_valid && op1 == swz(PAT2, VEC[7][31:0], 11), "R9 hold idle",
        op1, swz(PAT2, VEC[7][31:0], 11));
    src1_rdata = PAT1;

    // R4 / R5 decode boundaries
    dec_chk(7'h00, 5'h00, 2'd0, 7'h00, 2'd0, 4'h0);
    dec_chk(7'h0F, 5'h0F, 2'd0, 7'h0F, 2'd0, 4'hF);
    dec_chk(7'h10, 5'h10, 2'd1, 7'h00, 2'd1, 4'h0);
    dec_chk(7'h1F, 5'h1F, 2'd1, 7'h0F, 2'd1, 4'hF);
    dec_chk(7'h20, 5'h07, 2'd2, 7'h00, 2'd0, 4'h7);
    dec_chk(7'h7F, 5'h18, 2'd2, 7'h5F, 2'd1, 4'h8);

    // R11: unmapped addresses neither store nor advance
    cfg_wr(4'd0, 32'h0);
    cfg_wr(4'd9, 32'h0000000F);
    cfg_wr(4'd15, 32'h0000000F);
    cfg_wr(4'd4, 32'h00000001);
    issue(mk(6'h0, 7'h0, 7'h0, 5'h0, 5'd0));
    chk(dst_we == 4'b1000, "R11 entry0", {92'h0, dst_we}, {92'h0, 4'b1000});
    issue(mk(6'h0, 7'h0, 7'h0, 5'h0, 5'd1));
    chk(dst_we == VEC[1][35:32], "R11 entry1 untouched", {92'h0, dst_we}, {92'h0, VEC[1][35:32]});

    // R10: same-cycle write and lookup of entry 0
    cfg_wr(4'd0, 32'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd2; cfg_wdata = 32'h00000004;
    instr_valid = 1'b1; instr = mk(6'h0, 7'h0, 7'h0, 5'h0, 5'd0);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(dst_we == 4'b1000, "R10 old content", {92'h0, dst_we}, {92'h0, 4'b1000});
    @(negedge clk);
    instr_valid = 1'b0;
    chk(dst_we == 4'b0010, "R10 new content", {92'h0, dst_we}, {92'h0, 4'b0010});

    // R3: fill all 32 entries then overflow
    cfg_wr(4'd0, 32'h0);
    for (int k = 0; k < 31; k++) cfg_wr(4'(1 + k % 8), 32'h00000002);
    cfg_wr(4'd3, 32'h0000000A);
    cfg_wr(4'd5, 32'h00000005);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd8; cfg_wdata = 32'h00000005;
    instr_valid = 1'b1; instr = mk(6'h0, 7'h0, 7'h0, 5'h0, 5'd31);
    @(negedge clk);
    cfg_we = 1'b0;
    chk(dst_we == 4'b0101, "R3 last entry kept", {92'h0, dst_we}, {92'h0, 4'b0101});
    instr = mk(6'h0, 7'h0, 7'h0, 5'h0, 5'd0);
    @(negedge clk);
    instr_valid = 1'b0;
    chk(dst_we == 4'b0100, "R3 no wrap to entry0", {92'h0, dst_we}, {92'h0, 4'b0100});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule